// File: doc/BRIEF.md
# Pipelined Synchronous Dual-Port RAM

This block is a static memory with two ports, A and B, that are completely independent. Each port has its own clock, synchronous reset, address, write data, per-lane write enables, write/read select and two chip selects. One chip select is active low and the other is active high. Either port may read or write any word in any cycle, and both may touch the same word at once. A word is 18 bits wide and is split into two 9-bit lanes. The default depth is 16 words, which keeps simulation small.

Every input is captured in a register on the port's clock edge, and the access is performed from that captured copy. Read data then passes through an output register, so a read occupies two edges. A port drives its read bus only while an output-enable flag is high, and it reports that flag on a separate pin. When the flag is low the bus carries high impedance. A deselected cycle clears the flag, and a single selected cycle sets it again.

Two writes to the same word in the same cycle leave that word undefined. Software on the two sides must keep this from happening.

Top module: `dpram_pipe`

## Requirements
- R1: While reset is high, and after it until a selected access has passed both register stages, the port holds its drive flag low.
- R2: A read selected at clock edge k shows the stored word on the read bus after edge k+1. The value seen after edge k is the result of the access made one edge earlier.
- R3: A selected write with both lane enables high stores the whole word. Later reads from either port return that word.
- R4: Lane enable bit 0 controls word bits 8:0 and lane enable bit 1 controls bits 17:9. A disabled lane keeps its earlier contents.
- R5: If the low-active select is high or the high-active select is low at edge k, the drive flag is low after edge k+1.
- R6: A write request made while the port is deselected leaves memory unchanged.
- R7: After a deselect, one cycle with both selects active sets the drive flag again after the next edge.
- R8: A write cycle places the word's previous contents on the read bus of the writing port.
- R9: If one port reads a word in the same cycle that the other port writes it, the read returns the old value. A read in the following cycle returns the new value.
- R10: The two ports can access different words in the same cycle, and neither access disturbs the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a | input | 1 | Port A synchronous reset, active high |
| sel_n_a | input | 1 | Port A select, active low |
| sel_a | input | 1 | Port A select, active high |
| wr_a | input | 1 | Port A operation: 1 write, 0 read |
| lane_en_a | input | 2 | Port A lane write enables |
| addr_a | input | 4 | Port A word address |
| wdata_a | input | 18 | Port A write data |
| rdata_a | output | 18 | Port A read data, high impedance when not driving |
| drive_a | output | 1 | Port A output-enable flag |
| clk_b | input | 1 | Port B clock |
| rst_b | input | 1 | Port B synchronous reset, active high |
| sel_n_b | input | 1 | Port B select, active low |
| sel_b | input | 1 | Port B select, active high |
| wr_b | input | 1 | Port B operation: 1 write, 0 read |
| lane_en_b | input | 2 | Port B lane write enables |
| addr_b | input | 4 | Port B word address |
| wdata_b | input | 18 | Port B write data |
| rdata_b | output | 18 | Port B read data, high impedance when not driving |
| drive_b | output | 1 | Port B output-enable flag |

## Verification
The bench goes after the following corner cases:

- **Read and write on the same word.** A read on one port and a write on the other target the same word in the same cycle. A design that forwarded the write would return the new word one cycle too early.
- **Partial-lane writes.** A write enables only one lane. A design with the lane mapping swapped or ignored would corrupt the neighbouring 9 bits.
- **Deselect through each select.** The port is deselected once through the low-active select and once through the high-active select. A design that decoded only one polarity would keep driving, or would perform the blocked write, which a later read-back would expose.
- **Read latency and reactivation.** The bench probes the edge before data is due and the edge after reactivation. A design with one register stage too few or too many would move the drive flag and the data by a cycle.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

    localparam int LANE_W = 9;
    localparam int LANES  = 2;
    localparam int WORD_W = LANE_W * LANES;
    localparam int ADDR_W = 4;
    localparam int DEPTH  = 1 << ADDR_W;

    typedef logic [LANE_W-1:0]             lane_t;
    typedef logic [LANES-1:0][LANE_W-1:0]  word_t;
    typedef logic [ADDR_W-1:0]             addr_t;
    typedef logic [LANES-1:0]              lane_en_t;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // One captured access, as held between the input and output stages.
    typedef struct packed {
        op_e      op;
        addr_t    addr;
        word_t    data;
        lane_en_t lanes;
    } req_t;

    function automatic logic port_selected(input logic sel_low_n, input logic sel_high);
        return !sel_low_n && sel_high;
    endfunction

    function automatic op_e decode_op(input logic selected, input logic write);
        if (!selected)
            return OP_IDLE;
        return write ? OP_WRITE : OP_READ;
    endfunction

    // Port A's copy is the newest one when both marks agree.
    function automatic logic a_is_newest(input logic mark_from_a, input logic mark_from_b);
        return mark_from_a == mark_from_b;
    endfunction

endpackage

// File: rtl/dpram_in_reg.sv
module dpram_in_reg
    import dpram_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sel_n,
    input  logic     sel,
    input  logic     wr,
    input  lane_en_t lanes,
    input  addr_t    addr,
    input  word_t    data,
    output req_t     req
);

    always_ff @(posedge clk) begin
        if (rst) begin
            req <= '0;
        end else begin
            req.op    <= decode_op(port_selected(sel_n, sel), wr);
            req.addr  <= addr;
            req.data  <= data;
            req.lanes <= lanes;
        end
    end

endmodule

// File: rtl/dpram_core.sv
module dpram_core
    import dpram_pkg::*;
#(
    parameter int N_WORDS = DEPTH
)
(
    input  logic  clk_a,
    input  logic  clk_b,
    input  req_t  req_a,
    input  req_t  req_b,
    output word_t cur_a,
    output word_t cur_b
);

    // Each lane keeps one bank per writing port and a mark bit per port.
    // A write from A copies B's mark; a write from B stores the inverse
    // of A's mark. Comparing the marks tells which bank is newest.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        lane_t bank_a [N_WORDS];
        lane_t bank_b [N_WORDS];
        logic  mark_a [N_WORDS];
        logic  mark_b [N_WORDS];

        always_ff @(posedge clk_a) begin
            if (req_a.op == OP_WRITE && req_a.lanes[l]) begin
                bank_a[req_a.addr] <= req_a.data[l];
                mark_a[req_a.addr] <= mark_b[req_a.addr];
            end
        end

        always_ff @(posedge clk_b) begin
            if (req_b.op == OP_WRITE && req_b.lanes[l]) begin
                bank_b[req_b.addr] <= req_b.data[l];
                mark_b[req_b.addr] <= ~mark_a[req_b.addr];
            end
        end

        assign cur_a[l] = a_is_newest(mark_a[req_a.addr], mark_b[req_a.addr])
                        ? bank_a[req_a.addr] : bank_b[req_a.addr];
        assign cur_b[l] = a_is_newest(mark_a[req_b.addr], mark_b[req_b.addr])
                        ? bank_a[req_b.addr] : bank_b[req_b.addr];
    end

endmodule

// File: rtl/dpram_out_reg.sv
module dpram_out_reg
    import dpram_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  req_t  req,
    input  word_t cur,
    output word_t q,
    output logic  drive
);

    always_ff @(posedge clk) begin
        if (rst) begin
            drive <= 1'b0;
            q     <= '0;
        end else begin
            drive <= (req.op != OP_IDLE);
            if (req.op != OP_IDLE)
                q <= cur;
        end
    end

endmodule

// File: rtl/dpram_pipe.sv
module dpram_pipe
    import dpram_pkg::*;
(
    input  logic              clk_a,
    input  logic              rst_a,
    input  logic              sel_n_a,
    input  logic              sel_a,
    input  logic              wr_a,
    input  logic [LANES-1:0]  lane_en_a,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [WORD_W-1:0] wdata_a,
    output logic [WORD_W-1:0] rdata_a,
    output logic              drive_a,
    input  logic              clk_b,
    input  logic              rst_b,
    input  logic              sel_n_b,
    input  logic              sel_b,
    input  logic              wr_b,
    input  logic [LANES-1:0]  lane_en_b,
    input  logic [ADDR_W-1:0] addr_b,
    input  logic [WORD_W-1:0] wdata_b,
    output logic [WORD_W-1:0] rdata_b,
    output logic              drive_b
);

    req_t  req_a, req_b;
    word_t cur_a, cur_b;
    word_t q_a, q_b;

    dpram_in_reg u_in_a (
        .clk(clk_a), .rst(rst_a), .sel_n(sel_n_a), .sel(sel_a), .wr(wr_a),
        .lanes(lane_en_a), .addr(addr_a), .data(wdata_a), .req(req_a)
    );

    dpram_in_reg u_in_b (
        .clk(clk_b), .rst(rst_b), .sel_n(sel_n_b), .sel(sel_b), .wr(wr_b),
        .lanes(lane_en_b), .addr(addr_b), .data(wdata_b), .req(req_b)
    );

    dpram_core #(.N_WORDS(DEPTH)) u_core (
        .clk_a(clk_a), .clk_b(clk_b), .req_a(req_a), .req_b(req_b),
        .cur_a(cur_a), .cur_b(cur_b)
    );

    dpram_out_reg u_out_a (
        .clk(clk_a), .rst(rst_a), .req(req_a), .cur(cur_a), .q(q_a), .drive(drive_a)
    );

    dpram_out_reg u_out_b (
        .clk(clk_b), .rst(rst_b), .req(req_b), .cur(cur_b), .q(q_b), .drive(drive_b)
    );

    assign rdata_a = drive_a ? q_a : 'z;
    assign rdata_b = drive_b ? q_b : 'z;

endmodule

// File: rtl/dpram_chk.sv
module dpram_chk (
    input logic clk_a,
    input logic rst_a,
    input logic sel_n_a,
    input logic sel_a,
    input logic drive_a,
    input logic clk_b,
    input logic rst_b,
    input logic sel_n_b,
    input logic sel_b,
    input logic drive_b
);

    // R1: reset leaves the output flag low on the next edge.
    assert_reset_idle_R1_a: assert property (@(posedge clk_a) rst_a |=> !drive_a);
    assert_reset_idle_R1_b: assert property (@(posedge clk_b) rst_b |=> !drive_b);

    // R5: a deselected capture clears the flag one edge later.
    assert_deselect_R5_a: assert property (@(posedge clk_a) disable iff (rst_a)
        (sel_n_a || !sel_a) |-> ##2 !drive_a);
    assert_deselect_R5_b: assert property (@(posedge clk_b) disable iff (rst_b)
        (sel_n_b || !sel_b) |-> ##2 !drive_b);

    // R7: a single selected capture reinstates the flag one edge later.
    assert_reactivate_R7_a: assert property (@(posedge clk_a) disable iff (rst_a)
        (!sel_n_a && sel_a) |-> ##2 drive_a);
    assert_reactivate_R7_b: assert property (@(posedge clk_b) disable iff (rst_b)
        (!sel_n_b && sel_b) |-> ##2 drive_b);

endmodule

bind dpram_pipe dpram_chk u_chk (
    .clk_a(clk_a), .rst_a(rst_a), .sel_n_a(sel_n_a), .sel_a(sel_a), .drive_a(drive_a),
    .clk_b(clk_b), .rst_b(rst_b), .sel_n_b(sel_n_b), .sel_b(sel_b), .drive_b(drive_b)
);

// File: tb/tb_dpram_pipe.sv
module tb_dpram_pipe;

    logic        clk_a = 1'b0, clk_b = 1'b0;
    logic        rst_a, rst_b;
    logic        sel_n_a, sel_a, wr_a, sel_n_b, sel_b, wr_b;
    logic [1:0]  lane_en_a, lane_en_b;
    logic [3:0]  addr_a, addr_b;
    logic [17:0] wdata_a, wdata_b, rdata_a, rdata_b;
    logic        drive_a, drive_b;

    int pass_cnt = 0;
    int total_cnt = 0;
    bit done = 1'b0;

    dpram_pipe dut (
        .clk_a(clk_a), .rst_a(rst_a), .sel_n_a(sel_n_a), .sel_a(sel_a), .wr_a(wr_a),
        .lane_en_a(lane_en_a), .addr_a(addr_a), .wdata_a(wdata_a),
        .rdata_a(rdata_a), .drive_a(drive_a),
        .clk_b(clk_b), .rst_b(rst_b), .sel_n_b(sel_n_b), .sel_b(sel_b), .wr_b(wr_b),
        .lane_en_b(lane_en_b), .addr_b(addr_b), .wdata_b(wdata_b),
        .rdata_b(rdata_b), .drive_b(drive_b)
    );

    // 250 MHz on both ports, edges aligned
    always #2 begin
        clk_a = ~clk_a;
        clk_b = ~clk_b;
    end

    typedef struct packed {
        logic a_sn; logic a_s; logic a_wr; logic [1:0] a_le; logic [3:0] a_ad; logic [17:0] a_wd;
        logic b_sn; logic b_s; logic b_wr; logic [1:0] b_le; logic [3:0] b_ad; logic [17:0] b_wd;
        logic a_oe; logic a_ck; logic [17:0] a_q;
        logic b_oe; logic b_ck; logic [17:0] b_q;
        logic [3:0] rq;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        // R3 R10: both ports write different words
        '{1'b0,1'b1,1'b1,2'b11,4'd1,18'h12345, 1'b0,1'b1,1'b1,2'b11,4'd2,18'h0ABCD, 1'b1,1'b0,18'h0, 1'b1,1'b0,18'h0, 4'd3},
        // R10 R3: cross reads
        '{1'b0,1'b1,1'b0,2'b11,4'd2,18'h0, 1'b0,1'b1,1'b0,2'b11,4'd1,18'h0, 1'b1,1'b1,18'h0ABCD, 1'b1,1'b1,18'h12345, 4'd10},
        // R8: lane-0 write shows old word; R5: B deselected by low-active select
        '{1'b0,1'b1,1'b1,2'b01,4'd1,18'h3FFFF, 1'b1,1'b1,1'b1,2'b11,4'd2,18'h0, 1'b1,1'b1,18'h12345, 1'b0,1'b0,18'h0, 4'd8},
        // R4: lane 0 replaced; R6: B write blocked by high-active select low
        '{1'b0,1'b1,1'b0,2'b11,4'd1,18'h0, 1'b0,1'b0,1'b1,2'b11,4'd2,18'h0, 1'b1,1'b1,18'h123FF, 1'b0,1'b0,18'h0, 4'd4},
        // R6: word 2 intact; A lane-1 write of zero
        '{1'b0,1'b1,1'b1,2'b10,4'd1,18'h0, 1'b0,1'b1,1'b0,2'b11,4'd2,18'h0, 1'b1,1'b1,18'h123FF, 1'b1,1'b1,18'h0ABCD, 4'd6},
        // R9: A reads word 1 while B writes it
        '{1'b0,1'b1,1'b0,2'b11,4'd1,18'h0, 1'b0,1'b1,1'b1,2'b11,4'd1,18'h2AAAA, 1'b1,1'b1,18'h001FF, 1'b1,1'b1,18'h001FF, 4'd9},
        // R9: next read sees B's word
        '{1'b0,1'b1,1'b0,2'b11,4'd1,18'h0, 1'b0,1'b1,1'b0,2'b11,4'd2,18'h0, 1'b1,1'b1,18'h2AAAA, 1'b1,1'b1,18'h0ABCD, 4'd9},
        // R5: both deselected, each through a different select
        '{1'b0,1'b0,1'b0,2'b11,4'd0,18'h0, 1'b1,1'b1,1'b0,2'b11,4'd0,18'h0, 1'b0,1'b0,18'h0, 1'b0,1'b0,18'h0, 4'd5},
        // R7: one selected cycle reactivates both
        '{1'b0,1'b1,1'b0,2'b11,4'd2,18'h0, 1'b0,1'b1,1'b0,2'b11,4'd1,18'h0, 1'b1,1'b1,18'h0ABCD, 1'b1,1'b1,18'h2AAAA, 4'd7}
    };

    task automatic check(input string what, input int rq, input logic [17:0] got, input logic [17:0] exp);
        total_cnt++;
        if (got === exp) pass_cnt++;
        else $display("FAIL R%0d %s: got %h expected %h", rq, what, got, exp);
    endtask

    task automatic step();
        @(posedge clk_a);
        @(negedge clk_a);
    endtask

    task automatic drive_vec(input vec_t v);
        sel_n_a = v.a_sn; sel_a = v.a_s; wr_a = v.a_wr; lane_en_a = v.a_le; addr_a = v.a_ad; wdata_a = v.a_wd;
        sel_n_b = v.b_sn; sel_b = v.b_s; wr_b = v.b_wr; lane_en_b = v.b_le; addr_b = v.b_ad; wdata_b = v.b_wd;
    endtask

    task automatic check_vec(input int i);
        check($sformatf("vec %0d A drive", i), VEC[i].rq, {17'h0, drive_a}, {17'h0, VEC[i].a_oe});
        if (VEC[i].a_ck) check($sformatf("vec %0d A data", i), VEC[i].rq, rdata_a, VEC[i].a_q);
        check($sformatf("vec %0d B drive", i), VEC[i].rq, {17'h0, drive_b}, {17'h0, VEC[i].b_oe});
        if (VEC[i].b_ck) check($sformatf("vec %0d B data", i), VEC[i].rq, rdata_b, VEC[i].b_q);
    endtask

    task automatic deselect_both();
        sel_n_a = 1'b1; sel_a = 1'b1; wr_a = 1'b0;
        sel_n_b = 1'b1; sel_b = 1'b1; wr_b = 1'b0;
    endtask

    initial begin
        rst_a = 1'b1; rst_b = 1'b1;
        lane_en_a = 2'b11; lane_en_b = 2'b11;
        addr_a = '0; addr_b = '0; wdata_a = '0; wdata_b = '0;
        sel_n_a = 1'b0; sel_a = 1'b1; wr_a = 1'b0;
        sel_n_b = 1'b0; sel_b = 1'b1; wr_b = 1'b0;
        @(negedge clk_a);
        step(); step();
        // R1: idle after reset even though both ports are selected
        check("reset A drive", 1, {17'h0, drive_a}, 18'h0);
        check("reset B drive", 1, {17'h0, drive_b}, 18'h0);
        rst_a = 1'b0; rst_b = 1'b0;
        deselect_both();
        step();

        for (int i = 0; i < NV; i++) begin
            drive_vec(VEC[i]);
            step();
            if (i > 0) check_vec(i - 1);
        end
        deselect_both();
        step();
        check_vec(NV - 1);

        // R2: latency of a lone read after deselect
        sel_n_a = 1'b0; sel_a = 1'b1; wr_a = 1'b0; addr_a = 4'd1;
        step();
        check("R2 first edge A drive", 2, {17'h0, drive_a}, 18'h0);
        deselect_both();
        step();
        check("R2 second edge A drive", 2, {17'h0, drive_a}, 18'h1);
        check("R2 second edge A data", 2, rdata_a, 18'h2AAAA);
        step();
        check("R5 after lone read A drive", 5, {17'h0, drive_a}, 18'h0);

        // R1: reset in the middle of active reads
        sel_n_a = 1'b0; sel_a = 1'b1; sel_n_b = 1'b0; sel_b = 1'b1;
        step();
        rst_a = 1'b1; rst_b = 1'b1;
        step();
        check("mid reset A drive", 1, {17'h0, drive_a}, 18'h0);
        check("mid reset B drive", 1, {17'h0, drive_b}, 18'h0);
        rst_a = 1'b0; rst_b = 1'b0;
        step();
        check("post reset B drive", 1, {17'h0, drive_b}, 18'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", pass_cnt, total_cnt);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            total_cnt++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", pass_cnt, total_cnt);
            $finish;
        end
    end

endmodule